// File: doc/BRIEF.md
# Start-stop serial transmitter with character queue

This block turns characters written by a host into a start-stop serial bit stream. A 16-entry queue sits in front of the serializer. A host or a DMA engine can load several characters at once, and the line then sends them back to back with no idle time between frames. The frame format is chosen with four static inputs: 7 or 8 data bits, parity on or off, parity sense, and 1 or 2 stop bits. The format is captured when each character starts.

The bit period is not set inside the block. Each bit lasts exactly one bit tick. The tick comes from one of two sources: a one-cycle strobe from an internal rate generator, or the rising edge of an external serial clock pin, which the block synchronizes first. A request output stays high while the queue is empty, so it can drive an interrupt or pace DMA refills. An active-low clear-to-send input holds back the start of new characters; a frame already on the line always finishes. A clock-stop input freezes all state for power saving.

Top module: `async_tx_fifo`

## Requirements
- R1: After reset, `txd` is high, `fifoLevel` is 0, `fifoFull` is 0 and `txEmptyReq` is 1.
- R2: A frame is laid out as follows. It starts on a bit tick with one low start bit. The data bits follow, least significant first. With `dataBits8`=1 there are 8 data bits; with `dataBits8`=0 there are 7, taken from `wrData[6:0]`. Every bit lasts exactly one tick, and the line rests high between frames.
- R3: With `parityEn`=1, one parity bit follows the data. It makes the count of ones over the data and parity even when `parityOdd`=0, and odd when `parityOdd`=1. With `parityEn`=0 no parity bit is sent.
- R4: After the data (and parity, if enabled) come one high stop bit when `twoStop`=0, or two high stop bits when `twoStop`=1.
- R5: The queue holds 16 characters. `fifoLevel` reports how many are stored, and `fifoFull` is high when the level is 16.
- R6: A write (`wrEn`=1) while the queue is full is discarded. The queued contents and the level stay unchanged.
- R7: If a character is queued and `ctsN` is low when the last stop bit of a frame ends, the next start bit follows on that same tick, with no idle bit between the frames.
- R8: `txEmptyReq` is high exactly when `fifoLevel` is 0.
- R9: While `ctsN` is high, no new character starts. A frame already started runs to its last stop bit.
- R10: With `extSel`=0, bit ticks come from `intTick` and `extSck` is ignored. With `extSel`=1, each rising edge of `extSck` is one tick and `intTick` is ignored.
- R11: While `clkStop` is high, the block holds its state: ticks do not advance the line, writes are discarded, and `txd` keeps its value.
- R12: A write in the same cycle as a character start both take effect, and the level is unchanged. A write into an empty queue on a tick does not start a frame in that cycle.
- R13: The frame format is captured at the start bit. Changing the format inputs during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clkStop | input | 1 | Freeze all state while high |
| wrEn | input | 1 | Write strobe for the character queue |
| wrData | input | 8 | Character to queue |
| dataBits8 | input | 1 | 1 = 8 data bits, 0 = 7 |
| parityEn | input | 1 | 1 = send a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| twoStop | input | 1 | 1 = two stop bits, 0 = one |
| extSel | input | 1 | 1 = tick from extSck edges, 0 = from intTick |
| intTick | input | 1 | One-cycle bit strobe from the internal rate generator |
| extSck | input | 1 | External serial clock pin (asynchronous) |
| ctsN | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial line output |
| fifoLevel | output | 5 | Number of queued characters |
| fifoFull | output | 1 | Queue holds 16 characters |
| txEmptyReq | output | 1 | Queue-empty request for an interrupt or DMA |

## Verification
A host write and a character start that pops the queue can land in the same clock cycle. The bench forces this by raising `wrEn` and `intTick` together. In one case the queue already holds characters: the level must stay unchanged and all queued characters must later decode in order. In the other case the queue is empty: the level must rise to one while the line stays high. A clear-to-send change while a frame is on the line is also timed on purpose. The bench then checks that the running frame completes and that the following character waits.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic eightBits;
    logic parityEn;
    logic parityOdd;
    logic twoStop;
  } frameCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // pop head character and place a new frame on the line
    logic shift;  // advance one bit
    logic idle;   // frame finished, rest the line high
  } txStrobe_t;

  function automatic logic [CNT_W-1:0] frameLen(input frameCfg_t c);
    logic [CNT_W-1:0] n;
    n = CNT_W'(1);
    n = n + (c.eightBits ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1));
    n = n + CNT_W'(c.parityEn);
    n = n + (c.twoStop ? CNT_W'(2) : CNT_W'(1));
    return n;
  endfunction

  // bit 0 goes out first; unused upper positions stay high
  function automatic logic [FRAME_W-1:0] buildFrame(input logic [DATA_W-1:0] d,
                                                    input frameCfg_t c);
    logic [FRAME_W-1:0] f;
    logic [CNT_W-1:0]   pos;
    logic [DATA_W-1:0]  used;
    logic               par;
    f    = '1;
    f[0] = 1'b0;
    pos  = CNT_W'(1);
    used = d;
    if (!c.eightBits) used[DATA_W-1] = 1'b0;
    par = (^used) ^ c.parityOdd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < DATA_W - 1 || c.eightBits) begin
        f[pos] = d[i];
        pos    = pos + CNT_W'(1);
      end
    end
    if (c.parityEn) f[pos] = par;
    return f;
  endfunction

endpackage

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              freeze,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  frameCfg_t         cfg,
  input  txStrobe_t         strb,
  output logic              txd,
  output logic [LW-1:0]     level,
  output logic              full,
  output logic              empty
);

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [PW-1:0]      wrPtr, rdPtr;
  logic [LW-1:0]      count;
  logic [FRAME_W-1:0] shreg;
  logic               doPush, doPop;

  assign full   = (count == LW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = !freeze && wrEn && !full;
  assign doPop  = strb.load;
  assign level  = count;
  assign txd    = shreg[0];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + LW'(1);
        2'b01:   count <= count - LW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg <= '1;
    end else if (strb.load) begin
      shreg <= buildFrame(mem[rdPtr], cfg);
    end else if (strb.shift) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
    end else if (strb.idle) begin
      shreg <= '1;
    end
  end

  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= LW'(DEPTH));
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> count != '0);
  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrEn) |=> count <= $past(count));
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> ($stable(count) && $stable(shreg)));
  a_r12_push_pop: assert property (@(posedge clk) disable iff (!rstN)
    (doPush && doPop) |=> count == $past(count));
  a_r2_start_low: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> txd == 1'b0);
  a_r4_rest_high: assert property (@(posedge clk) disable iff (!rstN)
    strb.idle |=> txd == 1'b1);

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      freeze,
  input  logic      intTick,
  input  logic      extSck,
  input  logic      extSel,
  input  logic      ctsN,
  input  logic      fifoEmpty,
  input  frameCfg_t cfg,
  output txStrobe_t strb
);

  logic             extMeta, extSync, extPrev;
  logic             ctsMeta, ctsSyncN;
  logic             extRise, bitTick, canStart, lastBit;
  logic             active;
  logic [CNT_W-1:0] bitCnt, lenLat;

  // pin synchronizers run even while frozen
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extMeta  <= 1'b0;
      extSync  <= 1'b0;
      extPrev  <= 1'b0;
      ctsMeta  <= 1'b1;
      ctsSyncN <= 1'b1;
    end else begin
      extMeta  <= extSck;
      extSync  <= extMeta;
      extPrev  <= extSync;
      ctsMeta  <= ctsN;
      ctsSyncN <= ctsMeta;
    end
  end

  assign extRise  = extSync && !extPrev;
  assign bitTick  = !freeze && (extSel ? extRise : intTick);
  assign canStart = !fifoEmpty && !ctsSyncN;
  assign lastBit  = (bitCnt == lenLat - CNT_W'(1));

  always_comb begin
    strb = '0;
    if (bitTick) begin
      if (!active || lastBit) begin
        if (canStart)    strb.load = 1'b1;
        else if (active) strb.idle = 1'b1;
      end else begin
        strb.shift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
      lenLat <= CNT_W'(1);
    end else if (strb.load) begin
      active <= 1'b1;
      bitCnt <= '0;
      lenLat <= frameLen(cfg);
    end else if (strb.idle) begin
      active <= 1'b0;
    end else if (strb.shift) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    active |-> bitCnt < lenLat);
  a_r13_format_held: assert property (@(posedge clk) disable iff (!rstN)
    (active && !strb.load) |=> $stable(lenLat));
  a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    freeze |=> ($stable(bitCnt) && $stable(active)));
  a_r2_single_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

// File: rtl/async_tx_fifo.sv
module async_tx_fifo
  import sertx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkStop,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dataBits8,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              twoStop,
  input  logic              extSel,
  input  logic              intTick,
  input  logic              extSck,
  input  logic              ctsN,
  output logic              txd,
  output logic [LW-1:0]     fifoLevel,
  output logic              fifoFull,
  output logic              txEmptyReq
);

  frameCfg_t cfg;
  txStrobe_t strb;
  logic      fifoEmpty;

  assign cfg = '{eightBits: dataBits8, parityEn: parityEn,
                 parityOdd: parityOdd, twoStop: twoStop};
  assign txEmptyReq = fifoEmpty;

  sertx_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .freeze   (clkStop),
    .intTick  (intTick),
    .extSck   (extSck),
    .extSel   (extSel),
    .ctsN     (ctsN),
    .fifoEmpty(fifoEmpty),
    .cfg      (cfg),
    .strb     (strb)
  );

  sertx_datapath #(.DEPTH(DEPTH)) uData (
    .clk   (clk),
    .rstN  (rstN),
    .freeze(clkStop),
    .wrEn  (wrEn),
    .wrData(wrData),
    .cfg   (cfg),
    .strb  (strb),
    .txd   (txd),
    .level (fifoLevel),
    .full  (fifoFull),
    .empty (fifoEmpty)
  );

endmodule

// File: tb/async_tx_fifo_test.sv
`timescale 1ns/1ps
module async_tx_fifo_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clkStop = 1'b0, wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       dataBits8 = 1'b1, parityEn = 1'b0, parityOdd = 1'b0, twoStop = 1'b0;
  logic       extSel = 1'b0, intTick = 1'b0, extSck = 1'b0, ctsN = 1'b0;
  logic       txd, fifoFull, txEmptyReq;
  logic [4:0] fifoLevel;

  always #4 clk = ~clk;  // 125 MHz

  async_tx_fifo uut (
    .clk(clk), .rstN(rstN), .clkStop(clkStop), .wrEn(wrEn), .wrData(wrData),
    .dataBits8(dataBits8), .parityEn(parityEn), .parityOdd(parityOdd),
    .twoStop(twoStop), .extSel(extSel), .intTick(intTick), .extSck(extSck),
    .ctsN(ctsN), .txd(txd), .fifoLevel(fifoLevel), .fifoFull(fifoFull),
    .txEmptyReq(txEmptyReq)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int expQ [0:255];
  int head = 0, tail = 0, modelLvl = 0;
  // decoder format (what the frame in flight should use)
  int dBits = 8, dPar = 0, dOdd = 0, dStops = 1;
  int rxSt = 0, rxIdx = 0, rxData = 0, rxStopN = 0, idleRun = 0, framesSeen = 0;
  bit gapCheck = 0, sampleOn = 1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic decode(input logic b);
    case (rxSt)
      0: if (b == 1'b0) begin
           if (gapCheck && framesSeen > 0) chk("R7 idle gap between frames", idleRun, 0);
           rxSt = 1; rxIdx = 0; rxData = 0;
         end else idleRun++;
      1: begin
           rxData = rxData | (int'(b) << rxIdx);
           rxIdx++;
           if (rxIdx == dBits) begin rxSt = (dPar != 0) ? 2 : 3; rxStopN = 0; end
         end
      2: begin
           int ones = dOdd;
           for (int i = 0; i < dBits; i++) ones += (rxData >> i) & 1;
           chk("R3 parity bit", int'(b), ones % 2);
           rxSt = 3; rxStopN = 0;
         end
      default: begin
           chk("R4 stop bit high", int'(b), 1);
           rxStopN++;
           if (rxStopN == dStops) begin
             chk("R2 data bits", rxData, expQ[head] & ((1 << dBits) - 1));
             head++; framesSeen++; rxSt = 0; idleRun = 0;
           end
         end
    endcase
  endtask

  task automatic setFmt(input int eight, input int par, input int odd, input int two);
    dataBits8 = eight[0]; parityEn = par[0]; parityOdd = odd[0]; twoStop = two[0];
    dBits = eight ? 8 : 7; dPar = par; dOdd = odd; dStops = two ? 2 : 1;
  endtask

  task automatic wr(input int d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d[7:0];
    if (!clkStop && modelLvl < 16) begin expQ[tail] = d; tail++; modelLvl++; end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); intTick = 1'b1;
      @(negedge clk); intTick = 1'b0;
      if (sampleOn) decode(txd);
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic extBits(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); extSck = 1'b1;
      repeat (8) @(negedge clk);
      extSck = 1'b0;
      decode(txd);
      repeat (7) @(negedge clk);
    end
  endtask

  task automatic drained(input string req);
    chk(req, tail - head, 0);
    modelLvl = 0;
    chk("R8 request high when level zero", int'(txEmptyReq), 1);
    chk("R5 level after drain", int'(fifoLevel), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd idle high", int'(txd), 1);
    chk("R1 level zero", int'(fifoLevel), 0);
    chk("R1 full low", int'(fifoFull), 0);
    chk("R1 empty request high", int'(txEmptyReq), 1);

    // R2 R3 R4 R7 R8: sweep all twelve formats, four back-to-back characters each
    for (int f = 0; f < 12; f++) begin
      int len;
      setFmt(f % 2, (f / 2) % 3 != 0, (f / 2) % 3 == 2, f / 6);
      len = 1 + dBits + dPar + dStops;
      for (int c = 0; c < 4; c++) wr((f * 37 + c * 91 + 5) & 255);
      chk("R5 level after four writes", int'(fifoLevel), 4);
      chk("R8 request low while queued", int'(txEmptyReq), 0);
      framesSeen = 0; gapCheck = 1;
      tick(4 * len + 3);
      drained("R2 all characters received");
    end
    gapCheck = 0;

    // R5 R6 R9: fill with CTS held off
    setFmt(1, 0, 0, 0);
    ctsN = 1'b1; repeat (4) @(negedge clk);
    for (int c = 0; c < 20; c++) wr(200 + c);
    chk("R5 level at capacity", int'(fifoLevel), 16);
    chk("R5 full flag", int'(fifoFull), 1);
    tick(10);
    chk("R9 no start while CTS high", int'(fifoLevel), 16);
    chk("R9 line high while CTS high", int'(txd), 1);
    ctsN = 1'b0; repeat (4) @(negedge clk);
    framesSeen = 0; gapCheck = 1;
    tick(16 * 10 + 4);
    chk("R6 only sixteen frames sent", framesSeen, 16);
    drained("R6 queue contents intact");
    gapCheck = 0;

    // R9: CTS dropped mid-frame
    wr(8'h3C); wr(8'hA5);
    tick(1);
    ctsN = 1'b1;
    tick(12);
    chk("R9 running frame completed", tail - head, 1);
    chk("R9 next character held", int'(fifoLevel), 1);
    chk("R9 line rests high", int'(txd), 1);
    ctsN = 1'b0; repeat (4) @(negedge clk);
    tick(12);
    drained("R9 held character sent after CTS");

    // R13: format inputs change during a frame
    wr(8'hC3);
    tick(1);
    dataBits8 = 1'b0; parityEn = 1'b1; twoStop = 1'b1;
    tick(12);
    drained("R13 frame kept captured format");
    setFmt(1, 0, 0, 0);

    // R11: clock stop
    clkStop = 1'b1; repeat (2) @(negedge clk);
    wr(8'h11);
    chk("R11 write dropped while stopped", int'(fifoLevel), 0);
    clkStop = 1'b0;
    wr(8'h5A); wr(8'h96);
    tick(3);
    begin
      logic held;
      held = txd;
      clkStop = 1'b1; sampleOn = 0;
      tick(5);
      wr(8'h77);
      chk("R11 line held while stopped", int'(txd), int'(held));
      chk("R11 level held while stopped", int'(fifoLevel), 1);
      clkStop = 1'b0; sampleOn = 1;
    end
    tick(24);
    drained("R11 frames intact after stop");

    // R10: external clock source
    extSel = 1'b1;
    wr(8'h6E);
    tick(5);
    chk("R10 internal tick ignored", int'(fifoLevel), 1);
    chk("R10 line idle", int'(txd), 1);
    extBits(12);
    drained("R10 frame sent on external edges");
    extSel = 1'b0;
    // R10: external pin ignored in internal mode
    wr(8'h21);
    extBits(3);
    chk("R10 external pin ignored", int'(fifoLevel), 1);
    tick(12);
    drained("R10 back on internal tick");

    // R12: write on the same cycle as a character start
    wr(8'h0F); wr(8'hF0);
    @(negedge clk);
    intTick = 1'b1; wrEn = 1'b1; wrData = 8'h81;
    expQ[tail] = 8'h81; tail++;
    @(negedge clk);
    intTick = 1'b0; wrEn = 1'b0;
    decode(txd);
    chk("R12 level unchanged on push and pop", int'(fifoLevel), 2);
    repeat (2) @(negedge clk);
    tick(32);
    drained("R12 all three characters in order");
    // R12: write into empty queue on a tick
    @(negedge clk);
    intTick = 1'b1; wrEn = 1'b1; wrData = 8'h44;
    expQ[tail] = 8'h44; tail++;
    @(negedge clk);
    intTick = 1'b0; wrEn = 1'b0;
    chk("R12 no start from empty queue", int'(txd), 1);
    chk("R12 write into empty queue counted", int'(fifoLevel), 1);
    repeat (2) @(negedge clk);
    tick(12);
    drained("R12 late character sent");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule